// File: doc/BRIEF.md
# Four-Level Address Strap Decoder

This block works out how each of two address-select straps is wired: to ground, to the supply, to the bus clock line or to the bus data line. It does not sense analog levels. It compares the synchronously sampled strap levels with the sampled two-wire bus lines while a transmission is open. A strap that follows a bus line on every cycle of a transmission that contains at least one falling clock edge is taken to be tied to that line. Any other strap is read as a fixed level, using the value it has at the STOP condition.

The outcome is committed only at STOP, so the decoded address never changes partway through a transfer. The block watches every transmission on the bus, whichever device it addresses, and decodes each one again. A board can therefore restrap the address without cycling power. Up to the first STOP after reset, each strap is decoded from its live level. Since the idle bus is high, a strap tied to a bus line reads as supply in that period. From the two classifications the block drives three results to the slave and port logic: the four low address bits, the input pullup enables for two nibbles, and the power-up default for two output nibbles.

Top module: `addr_strap_decoder`

## Requirements
- R1: From reset until the first STOP, each strap is classified from its sampled level alone: high reads as supply and low reads as ground. A strap tied to an idle (high) bus line therefore reads as supply.
- R2: A strap that equals the clock line on every cycle of a transmission with at least one falling clock edge is classified as clock-tied when that transmission's STOP arrives.
- R3: A strap that equals the data line on every cycle of such a transmission is classified as data-tied when the STOP arrives.
- R4: A strap that follows neither line during a transmission is classified at STOP from its level in that cycle: 1 gives supply and 0 gives ground.
- R5: After the first STOP, a classification changes only in the cycle after a STOP. A strap rewired in the middle of a transfer or on an idle bus leaves the outputs unchanged until the next STOP.
- R6: addr_lo_o[3:2] encodes the high strap as clock→00, data→01, ground→10, supply→11.
- R7: addr_lo_o[1:0] encodes the low strap as ground→00, supply→01, clock→10, data→11.
- R8: pullup_en_o[3:0] follows the low strap and pullup_en_o[7:4] follows the high strap. A nibble is all ones unless its strap is ground, in which case it is all zeros.
- R9: out_dflt_o[3:0] (outputs 8–11) follows the low strap and out_dflt_o[7:4] (outputs 12–15) follows the high strap. A nibble is 0000 for a ground strap and 1111 for any other connection.
- R10: A transmission whose STOP comes before any falling clock edge classifies both straps as fixed levels, even a strap that is wired to a bus line.
- R11: Every transmission is decoded again regardless of the bytes sent, so successive transmissions with different wirings each produce the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sel_lo_i | input | 1 | Sampled low address strap |
| sel_hi_i | input | 1 | Sampled high address strap |
| addr_lo_o | output | 4 | Decoded low address bits |
| pullup_en_o | output | 8 | Input pullup enables, two nibbles |
| out_dflt_o | output | 8 | Output power-up default, two nibbles |

## Verification
All sixteen wirings of the two straps are applied, each followed by one full byte transfer. A change in any code shows up as a wrong address, pullup or default nibble. A STOP with no clock edge separates the edge-qualified bus match from the fixed-level fallback. A strap that is rewired while the bus is idle and again in the middle of a byte separates commit-at-STOP from continuous update. The reset check with a clock-tied strap confirms that the idle-high assumption holds before the first STOP.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic [1:0] {
        CONN_GND = 2'd0,
        CONN_VDD = 2'd1,
        CONN_SCL = 2'd2,
        CONN_SDA = 2'd3
    } conn_e;

    function automatic logic [1:0] code_lo(input conn_e c);
        return logic'(c[1]) ? {1'b1, c[0]} : {1'b0, c[0]};
    endfunction

    function automatic logic [1:0] code_hi(input conn_e c);
        return {~c[1], c[0]};
    endfunction
endpackage

// File: rtl/bus_frame_detect.sv
module bus_frame_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic active_o,
    output logic scl_fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic active;
    } bus_st_t;

    bus_st_t st_d, st_q;

    always_comb begin
        start_o    = st_q.scl && scl_i && st_q.sda && !sda_i;
        stop_o     = st_q.active && st_q.scl && scl_i && !st_q.sda && sda_i;
        scl_fall_o = st_q.scl && !scl_i;
        active_o   = st_q.active;
        st_d       = st_q;
        st_d.scl   = scl_i;
        st_d.sda   = sda_i;
        if (start_o)     st_d.active = 1'b1;
        else if (stop_o) st_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scl: 1'b1, sda: 1'b1, active: 1'b0};
        else        st_q <= st_d;
    end

    // R11: a transmission opens only on a START condition
    assert_open_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(start_o));
endmodule

// File: rtl/strap_tracker.sv
module strap_tracker
    import strap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_i,
    input  logic  scl_i,
    input  logic  sda_i,
    input  logic  start_i,
    input  logic  stop_i,
    input  logic  active_i,
    input  logic  scl_fall_i,
    output conn_e conn_o
);
    typedef struct packed {
        logic  m_scl;
        logic  m_sda;
        logic  saw_edge;
        logic  valid;
        conn_e conn;
    } trk_st_t;

    trk_st_t st_d, st_q;
    conn_e   level_c;

    always_comb begin
        level_c = pin_i ? CONN_VDD : CONN_GND;
        st_d    = st_q;
        if (!st_q.valid) st_d.conn = level_c;
        if (active_i) begin
            st_d.m_scl = st_q.m_scl && (pin_i == scl_i);
            st_d.m_sda = st_q.m_sda && (pin_i == sda_i);
            if (scl_fall_i) st_d.saw_edge = 1'b1;
        end
        if (stop_i) begin
            st_d.valid = 1'b1;
            if (st_q.saw_edge && st_d.m_scl)      st_d.conn = CONN_SCL;
            else if (st_q.saw_edge && st_d.m_sda) st_d.conn = CONN_SDA;
            else                                  st_d.conn = level_c;
        end
        if (start_i) begin
            st_d.m_scl    = 1'b1;
            st_d.m_sda    = 1'b1;
            st_d.saw_edge = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{m_scl: 1'b1, m_sda: 1'b1, saw_edge: 1'b0,
                              valid: 1'b0, conn: CONN_VDD};
        else        st_q <= st_d;
    end

    assign conn_o = st_q.conn;

    // R5: once committed, the class moves only right after a STOP
    assert_hold_between_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $past(st_q.valid) && !$past(stop_i)) |-> $stable(st_q.conn));
    // R1: bus-tied classes never appear before the first STOP
    assert_bus_class_needs_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.conn == CONN_SCL || st_q.conn == CONN_SDA) |-> st_q.valid);
endmodule

// File: rtl/strap_encode.sv
module strap_encode
    import strap_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  conn_e              conn_lo_i,
    input  conn_e              conn_hi_i,
    output logic [3:0]         addr_o,
    output logic [2*NIB_W-1:0] pull_o,
    output logic [2*NIB_W-1:0] dflt_o
);
    conn_e sides [2];
    assign sides[0] = conn_lo_i;
    assign sides[1] = conn_hi_i;

    assign addr_o = {code_hi(conn_hi_i), code_lo(conn_lo_i)};

    for (genvar g = 0; g < 2; g++) begin : g_nib
        logic high_c;
        assign high_c = (sides[g] != CONN_GND);
        assign pull_o[g*NIB_W +: NIB_W] = {NIB_W{high_c}};
        assign dflt_o[g*NIB_W +: NIB_W] = {NIB_W{high_c}};
    end
endmodule

// File: rtl/addr_strap_decoder.sv
module addr_strap_decoder
    import strap_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int PW   = 2 * NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          sel_lo_i,
    input  logic          sel_hi_i,
    output logic [3:0]    addr_lo_o,
    output logic [PW-1:0] pullup_en_o,
    output logic [PW-1:0] out_dflt_o
);
    logic  start_w, stop_w, active_w, fall_w;
    conn_e conn_lo_w, conn_hi_w;

    bus_frame_detect u_frame (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .start_o(start_w), .stop_o(stop_w), .active_o(active_w), .scl_fall_o(fall_w)
    );

    strap_tracker u_trk_lo (
        .clk(clk), .rst_n(rst_n), .pin_i(sel_lo_i), .scl_i(scl_i), .sda_i(sda_i),
        .start_i(start_w), .stop_i(stop_w), .active_i(active_w),
        .scl_fall_i(fall_w), .conn_o(conn_lo_w)
    );

    strap_tracker u_trk_hi (
        .clk(clk), .rst_n(rst_n), .pin_i(sel_hi_i), .scl_i(scl_i), .sda_i(sda_i),
        .start_i(start_w), .stop_i(stop_w), .active_i(active_w),
        .scl_fall_i(fall_w), .conn_o(conn_hi_w)
    );

    strap_encode #(.NIB_W(NIB_W)) u_enc (
        .conn_lo_i(conn_lo_w), .conn_hi_i(conn_hi_w),
        .addr_o(addr_lo_o), .pull_o(pullup_en_o), .dflt_o(out_dflt_o)
    );

    // R8: a ground low strap (code 00) leaves the low pullup nibble off
    assert_gnd_no_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lo_o[1:0] == 2'b00) |-> (pullup_en_o[NIB_W-1:0] == '0));
    // R9: a ground high strap (code 10) gives an all-zero upper default nibble
    assert_gnd_low_dflt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lo_o[3:2] == 2'b10) |-> (out_dflt_o[PW-1:NIB_W] == '0));
endmodule

// File: tb/tb_addr_strap_decoder.sv
module tb_addr_strap_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    int   wire_lo = 1, wire_hi = 1;   // 0 gnd, 1 supply, 2 clock, 3 data
    int   cm_lo = 1, cm_hi = 1;       // committed model
    logic sel_lo, sel_hi;
    logic [3:0] addr;
    logic [7:0] pull, dflt;
    int total = 0, bad = 0;
    bit finished = 0;

    typedef struct { logic [19:0] exp; string tag; } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    function automatic logic strap_lvl(int w, logic c, logic d);
        case (w)
            0: return 1'b0;
            1: return 1'b1;
            2: return c;
            default: return d;
        endcase
    endfunction

    assign sel_lo = strap_lvl(wire_lo, scl, sda);
    assign sel_hi = strap_lvl(wire_hi, scl, sda);

    addr_strap_decoder dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sel_lo_i(sel_lo), .sel_hi_i(sel_hi),
        .addr_lo_o(addr), .pullup_en_o(pull), .out_dflt_o(dflt)
    );

    function automatic logic [19:0] model(int lo, int hi);
        logic [1:0] ch, cl;
        logic [3:0] nl, nh;
        cl = 2'(lo);                                   // R7 table
        case (hi) 2: ch = 2'b00; 3: ch = 2'b01; 0: ch = 2'b10; default: ch = 2'b11; endcase // R6
        nl = (lo == 0) ? 4'h0 : 4'hF;
        nh = (hi == 0) ? 4'h0 : 4'hF;
        return {ch, cl, nh, nl, nh, nl};               // addr, pull (R8), dflt (R9)
    endfunction

    task automatic expect_now(string tag);
        item_t it;
        it.exp = model(cm_lo, cm_hi);
        it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                total++;
                if ({addr, pull, dflt} !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, {addr, pull, dflt}, it.exp);
                end
            end
        end
    end

    task automatic hold();
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(logic [7:0] data, bit edges, bit mid_chk, int new_lo);
        sda = 1'b0; hold();                       // START
        if (edges) begin
            for (int i = 7; i >= 0; i--) begin
                scl = 1'b0; sda = data[i]; hold();
                if (mid_chk && i == 4) begin
                    wire_lo = new_lo; hold();
                    expect_now("R5 mid-transfer rewire");
                end
                scl = 1'b1; hold();
            end
            scl = 1'b0; sda = 1'b0; hold();
            scl = 1'b1; hold();
            scl = 1'b0; hold();
        end
        scl = 1'b1; hold();
        sda = 1'b1; hold();                        // STOP
        if (edges) begin cm_lo = wire_lo; cm_hi = wire_hi; end
        else begin cm_lo = (wire_lo == 0) ? 0 : 1; cm_hi = (wire_hi == 0) ? 0 : 1; end
    endtask

    initial begin : driver
        wire_lo = 2; wire_hi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hold();
        cm_lo = 1; cm_hi = 0;
        expect_now("R1 reset: clock strap reads supply");
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 4; l++) begin
                wire_lo = l; wire_hi = h;
                xfer(8'(8'h3C ^ (h * 16 + l * 5)), 1'b1, 1'b0, 0);
                expect_now($sformatf("R2 R3 R4 R6 R7 R8 R9 R11 lo=%0d hi=%0d", l, h));
            end
        end
        wire_lo = 3; wire_hi = 2;
        xfer(8'hA5, 1'b1, 1'b0, 0);
        expect_now("R2 R3 bus-tied pair");
        wire_lo = 1; hold();
        expect_now("R5 idle rewire ignored");
        xfer(8'h0F, 1'b1, 1'b1, 0);
        expect_now("R4 R5 commit at STOP");
        wire_lo = 2; wire_hi = 3;
        xfer(8'h00, 1'b0, 1'b0, 0);
        expect_now("R10 no clock edge gives fixed levels");
        xfer(8'hFF, 1'b1, 1'b0, 0);
        expect_now("R11 next transmission redecodes");
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule